// File: doc/BRIEF.md
# SECDED Protected Memory with Background Scrubbing

This block is a single-port word memory in which every stored word carries Hamming check bits and one overall parity bit. A host reads and writes through a valid/ready port. On a read, a single flipped bit anywhere in the stored codeword is corrected in the returned data. Two flipped bits are detected and flagged, and the data is not trusted. A read that corrects a word does not change what is held in the array.

A scrub engine repairs the array itself. After a programmable number of idle host cycles it reads the next location. If that word has a correctable error, the engine holds the repaired codeword and writes it back on the next cycle the host leaves free. Over time it visits every address and wraps at the top. Host requests always win the array. A host write to the address whose repair is still pending cancels that write-back. Words with two errors are reported and left untouched.

Error events come out as one-cycle pulses, with separate pulses for host reads and scrub reads, together with the address involved. Each host write takes a flip mask that is XORed into the stored codeword. This lets test code plant upsets through the normal port.

Top module: `ecc_scrub_mem`

## Requirements
- R1: `req_ready` is always 1. A read accepted at clock edge k drives `rsp_valid` high, with `rsp_rdata`, for exactly the one cycle that follows edge k+1. A write accepted at edge k is visible to a read accepted at edge k+1 or later.
- R2: The stored codeword is DW+R+1 bits, where R is the smallest value with 2^R >= DW+R+1. For DW=32 this gives 39 bits. On a host write, the stored codeword is the encoded word XOR `req_flip`. Any single set bit of `req_flip` at positions 0..38, the lowest and highest included, makes a correctable word. Any two set bits make an uncorrectable word.
- R3: On a host read of a word with one flipped bit, `rsp_rdata` equals the written data, `host_ce` pulses with the response, and `err_addr` holds the read address.
- R4: On a host read of a word with two flipped bits, `host_ue` pulses with the response, `host_ce` stays low, and `err_addr` holds the read address.
- R5: A host read that corrects a word leaves the stored codeword unchanged, so reading the same address again flags `host_ce` again.
- R6: While `scrub_gap` is nonzero, the scrubber visits addresses in ascending order and wraps from the last address to 0. For each correctable word it pulses `scrub_ce` with the address in `err_addr` and rewrites the repaired codeword, so a later host read returns the data with no error flag.
- R7: For an uncorrectable word the scrubber pulses `scrub_ue` with the address and does not write back. A later host read still flags `host_ue`.
- R8: `scrub_gap` = 0 stops the scrubber from starting reads, so no scrub pulse occurs.
- R9: With the host idle and every visited word correctable, consecutive `scrub_ce` pulses are exactly `scrub_gap`+2 cycles apart: G idle cycles, one read cycle and one write-back cycle.
- R10: The scrubber reads or writes the array only in cycles with no host request. During back-to-back host requests no scrub pulse appears, and host responses are unaffected.
- R11: A host write to the address whose scrub write-back is pending cancels that write-back, and a later read returns the host's data.
- R12: The four error pulses are one-hot or all low in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scrub_gap | input | GAP_W | Idle cycles between scrub steps; 0 stops scrubbing |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_flip | input | DW+R+1 | Bits XORed into the stored codeword on write |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Corrected read data |
| host_ce | output | 1 | Host read corrected a single error |
| host_ue | output | 1 | Host read found an uncorrectable word |
| scrub_ce | output | 1 | Scrub read corrected a single error |
| scrub_ue | output | 1 | Scrub read found an uncorrectable word |
| err_addr | output | AW | Address of the latest error pulse |

## Verification
The bench builds the block with DW=32, which gives a 39-bit codeword, so single flips on the lowest parity bit and on the highest position can both be planted. AW=4 gives 16 locations, so a full scrub sweep and the wrap back to address 0 happen within a few hundred cycles. GAP_W=8, and the bench uses gap values 0, 1, 3 and 5. These values let it measure the scrub step period exactly, stop the scrubber for deterministic host-side checks, and catch a pending write-back in the one cycle where a host write can cancel it.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

    // Smallest number of Hamming check bits that covers dw data bits.
    function automatic int check_bits(input int dw);
        for (int r = 1; r < 31; r++) begin
            if ((1 << r) >= dw + r + 1) return r;
        end
        return 31;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    typedef struct packed {
        logic ce;
        logic ue;
    } ecc_flags_t;

    typedef enum logic [1:0] {
        SC_WAIT = 2'd0,
        SC_READ = 2'd1,
        SC_HOLD = 2'd2
    } scrub_state_e;

    typedef enum logic {
        SRC_HOST  = 1'b0,
        SRC_SCRUB = 1'b1
    } rd_src_e;

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
    parameter int DW = 32,
    parameter int R  = ecc_scrub_pkg::check_bits(DW),
    parameter int N  = DW + R
) (
    input  logic [DW-1:0] data,
    output logic [N:0]    cw
);
    import ecc_scrub_pkg::*;

    // Data bits sit on the non-power-of-two positions 1..N; check bit i
    // sits on position 2^i; position 0 is the overall parity bit.
    always_comb begin
        logic [N:0]   w;
        logic [R-1:0] x;
        int           j;
        w = '0;
        x = '0;
        j = 0;
        for (int p = 1; p <= N; p++) begin
            if (!is_pow2(p)) begin
                w[p] = data[j];
                if (data[j]) x = x ^ R'(p);
                j++;
            end
        end
        for (int i = 0; i < R; i++) w[1 << i] = x[i];
        w[0] = ^w[N:1];
        cw = w;
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
    parameter int DW = 32,
    parameter int R  = ecc_scrub_pkg::check_bits(DW),
    parameter int N  = DW + R
) (
    input  logic [N:0]                     cw,
    output logic [N:0]                     cw_fix,
    output logic [DW-1:0]                  data,
    output ecc_scrub_pkg::ecc_flags_t      flags
);
    import ecc_scrub_pkg::*;

    logic [R-1:0] syn;
    logic         ovp;

    always_comb begin
        syn = '0;
        for (int p = 1; p <= N; p++) begin
            if (cw[p]) syn = syn ^ R'(p);
        end
        ovp = ^cw;
    end

    always_comb begin
        logic [N:0] f;
        int         j;
        f        = cw;
        flags    = '0;
        if (ovp) begin
            if (int'(syn) <= N) begin
                flags.ce = 1'b1;
                f[syn]   = ~f[syn];
            end else begin
                flags.ue = 1'b1;
            end
        end else if (syn != '0) begin
            flags.ue = 1'b1;
        end
        cw_fix = f;
        data   = '0;
        j      = 0;
        for (int p = 1; p <= N; p++) begin
            if (!is_pow2(p)) begin
                data[j] = f[p];
                j++;
            end
        end
    end

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl #(
    parameter int AW    = 4,
    parameter int CW    = 39,
    parameter int GAP_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [GAP_W-1:0]              gap,
    input  logic                          host_valid,
    input  logic                          host_write,
    input  logic [AW-1:0]                 host_addr,
    input  ecc_scrub_pkg::ecc_flags_t     rd_flags,
    input  logic [CW-1:0]                 rd_fix,
    output logic                          scrub_rd,
    output logic [AW-1:0]                 scrub_addr,
    output logic                          wb_en,
    output logic [AW-1:0]                 wb_addr,
    output logic [CW-1:0]                 wb_cw,
    output ecc_scrub_pkg::ecc_flags_t     ev,
    output logic [AW-1:0]                 ev_addr
);
    import ecc_scrub_pkg::*;

    scrub_state_e   state;
    logic [GAP_W-1:0] cnt;
    logic [AW-1:0]  ptr;
    logic [AW-1:0]  cur_addr;
    logic [CW-1:0]  hold_cw;
    logic           host_hit;
    logic           idle_step;

    assign host_hit   = host_valid && host_write && (host_addr == cur_addr);
    assign idle_step  = (state == SC_WAIT) && !host_valid && (gap != '0);
    assign scrub_rd   = idle_step && (({1'b0, cnt} + 1'b1) >= {1'b0, gap});
    assign scrub_addr = ptr;
    assign wb_en      = (state == SC_HOLD) && !host_valid;
    assign wb_addr    = cur_addr;
    assign wb_cw      = hold_cw;
    assign ev         = (state == SC_READ) ? rd_flags : '0;
    assign ev_addr    = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SC_WAIT;
            cnt      <= '0;
            ptr      <= '0;
            cur_addr <= '0;
            hold_cw  <= '0;
        end else begin
            case (state)
                SC_WAIT: begin
                    if (scrub_rd) begin
                        cnt      <= '0;
                        cur_addr <= ptr;
                        ptr      <= ptr + 1'b1;
                        state    <= SC_READ;
                    end else if (idle_step) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SC_READ: begin
                    if (rd_flags.ce && !host_hit) begin
                        hold_cw <= rd_fix;
                        state   <= SC_HOLD;
                    end else begin
                        state <= SC_WAIT;
                    end
                end
                SC_HOLD: begin
                    if (host_hit || wb_en) state <= SC_WAIT;
                end
                default: state <= SC_WAIT;
            endcase
        end
    end

    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (rst)
        host_valid |-> !scrub_rd && !wb_en); // R10
    AST_GAP_OFF: assert property (@(posedge clk) disable iff (rst)
        (gap == '0) |-> !scrub_rd); // R8
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (scrub_rd && scrub_addr == '1) |=> (scrub_addr == '0)); // R6

endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem #(
    parameter int DW    = 32,
    parameter int AW    = 4,
    parameter int GAP_W = 8,
    parameter int R     = ecc_scrub_pkg::check_bits(DW),
    parameter int CW    = DW + R + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GAP_W-1:0] scrub_gap,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [CW-1:0]    req_flip,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             host_ce,
    output logic             host_ue,
    output logic             scrub_ce,
    output logic             scrub_ue,
    output logic [AW-1:0]    err_addr
);
    import ecc_scrub_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam int N     = CW - 1;

    logic [CW-1:0] mem [DEPTH];
    logic [CW-1:0] mem_q;
    logic [CW-1:0] enc_cw;
    logic [CW-1:0] fix_cw;
    logic [DW-1:0] dec_data;
    ecc_flags_t    dec_flags;
    ecc_flags_t    scr_ev;
    logic [AW-1:0] scr_ev_addr;
    logic          scr_rd;
    logic [AW-1:0] scr_addr;
    logic          wb_en;
    logic [AW-1:0] wb_addr;
    logic [CW-1:0] wb_cw;
    logic          rd_live;
    rd_src_e       rd_src;
    logic [AW-1:0] rd_addr_q;
    logic          host_rd;
    logic          host_rd_req;

    assign req_ready   = 1'b1;
    assign host_rd_req = req_valid && !req_write;
    assign host_rd     = rd_live && (rd_src == SRC_HOST);

    secded_enc #(.DW(DW), .R(R), .N(N)) u_enc (
        .data (req_wdata),
        .cw   (enc_cw)
    );

    secded_dec #(.DW(DW), .R(R), .N(N)) u_dec (
        .cw     (mem_q),
        .cw_fix (fix_cw),
        .data   (dec_data),
        .flags  (dec_flags)
    );

    scrub_ctrl #(.AW(AW), .CW(CW), .GAP_W(GAP_W)) u_scrub (
        .clk        (clk),
        .rst        (rst),
        .gap        (scrub_gap),
        .host_valid (req_valid),
        .host_write (req_write),
        .host_addr  (req_addr),
        .rd_flags   (dec_flags),
        .rd_fix     (fix_cw),
        .scrub_rd   (scr_rd),
        .scrub_addr (scr_addr),
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_cw      (wb_cw),
        .ev         (scr_ev),
        .ev_addr    (scr_ev_addr)
    );

    // Storage array: one access per cycle, host first.
    always_ff @(posedge clk) begin
        if (req_valid && req_write) begin
            mem[req_addr] <= enc_cw ^ req_flip;
        end else if (wb_en) begin
            mem[wb_addr] <= wb_cw;
        end
        if (host_rd_req) begin
            mem_q <= mem[req_addr];
        end else if (scr_rd) begin
            mem_q <= mem[scr_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_live   <= 1'b0;
            rd_src    <= SRC_HOST;
            rd_addr_q <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            host_ce   <= 1'b0;
            host_ue   <= 1'b0;
            scrub_ce  <= 1'b0;
            scrub_ue  <= 1'b0;
            err_addr  <= '0;
        end else begin
            rd_live <= host_rd_req || scr_rd;
            if (host_rd_req) begin
                rd_src    <= SRC_HOST;
                rd_addr_q <= req_addr;
            end else if (scr_rd) begin
                rd_src <= SRC_SCRUB;
            end
            rsp_valid <= host_rd;
            if (host_rd) rsp_rdata <= dec_data;
            host_ce  <= host_rd && dec_flags.ce;
            host_ue  <= host_rd && dec_flags.ue;
            scrub_ce <= scr_ev.ce;
            scrub_ue <= scr_ev.ue;
            if (host_rd && (dec_flags.ce || dec_flags.ue)) begin
                err_addr <= rd_addr_q;
            end else if (scr_ev.ce || scr_ev.ue) begin
                err_addr <= scr_ev_addr;
            end
        end
    end

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |-> ##2 rsp_valid); // R1
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({host_ce, host_ue, scrub_ce, scrub_ue})); // R12
    AST_UE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        scrub_ue |-> !wb_en); // R7
    AST_WB_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == wb_addr) |=> !wb_en); // R11

endmodule

// File: tb/ecc_scrub_mem_tb.sv
module ecc_scrub_mem_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int GW = 8;
    localparam int DEPTH = 1 << AW;

    function automatic int tb_check_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction
    localparam int CW = DW + tb_check_bits(DW) + 1;

    logic clk = 0, rst = 1;
    logic [GW-1:0] scrub_gap = '0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [CW-1:0] req_flip = '0;
    logic req_ready, rsp_valid, host_ce, host_ue, scrub_ce, scrub_ue;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] err_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_scrub_mem #(.DW(DW), .AW(AW), .GAP_W(GW)) u_dut (
        .clk(clk), .rst(rst), .scrub_gap(scrub_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_flip(req_flip),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .host_ce(host_ce), .host_ue(host_ue),
        .scrub_ce(scrub_ce), .scrub_ue(scrub_ue), .err_addr(err_addr)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    logic [DW-1:0] mdata [DEPTH];
    int merr [DEPTH];
    bit mon_on = 0;
    int seen_ce [DEPTH];
    int seen_ue [DEPTH];
    int scrub_events = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (scrub_ce) seen_ce[err_addr]++;
            if (scrub_ue) seen_ue[err_addr]++;
            if (scrub_ce || scrub_ue) scrub_events++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int expect_err(input logic [CW-1:0] f);
        int c;
        c = $countones(f);
        return (c > 2) ? 2 : c;
    endfunction

    function automatic logic [CW-1:0] one_flip();
        return CW'(1) << $urandom_range(CW-1);
    endfunction

    function automatic logic [CW-1:0] two_flip();
        int p1, p2;
        p1 = $urandom_range(CW-1);
        p2 = (p1 + 1 + $urandom_range(CW-2)) % CW;
        return (CW'(1) << p1) | (CW'(1) << p2);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [CW-1:0] f);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_flip = f;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_flip = '0;
        mdata[a] = d;
        merr[a] = expect_err(f);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        check(rsp_valid == 1'b1, {tag, " R1 rsp_valid"}, 64'(rsp_valid), 64'd1);
        if (merr[a] < 2) begin
            check(rsp_rdata == mdata[a], {tag, " R3 data"}, 64'(rsp_rdata), 64'(mdata[a]));
            check(host_ce == (merr[a] == 1), {tag, " R3 host_ce"}, 64'(host_ce), 64'(merr[a] == 1));
            check(host_ue == 1'b0, {tag, " R4 host_ue"}, 64'(host_ue), 64'd0);
        end else begin
            check(host_ue == 1'b1, {tag, " R4 host_ue"}, 64'(host_ue), 64'd1);
            check(host_ce == 1'b0, {tag, " R4 host_ce"}, 64'(host_ce), 64'd0);
        end
        if (merr[a] != 0)
            check(err_addr == a, {tag, " R3 err_addr"}, 64'(err_addr), 64'(a));
    endtask

    // Wait for the next scrub_ce pulse; returns negedge count waited (or -1).
    task automatic wait_ce(output int n);
        n = -1;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (scrub_ce) begin n = i; break; end
        end
    endtask

    initial begin
        int unsigned seed_dummy;
        int n1, n2;
        bit hit;
        logic [DW-1:0] d2;
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < DEPTH; i++) begin
            mdata[i] = '0; merr[i] = 0; seen_ce[i] = 0; seen_ue[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // Reset state
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check({host_ce, host_ue, scrub_ce, scrub_ue} == 4'b0, "R12 pulses after reset",
              64'({host_ce, host_ue, scrub_ce, scrub_ue}), 64'd0);

        // Fill clean, read back
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), $urandom, '0);
        for (int a = 0; a < DEPTH; a++) rd_check(AW'(a), "clean");

        // Boundary flips: lowest and highest codeword bit (R2)
        wr(4'd2, 32'hFFFF_FFFF, CW'(1));
        rd_check(4'd2, "R2 flip bit0");
        wr(4'd3, 32'h0000_0000, CW'(1) << (CW-1));
        rd_check(4'd3, "R2 flip top");
        wr(4'd4, 32'hA5A5_5A5A, CW'(1) | (CW'(1) << (CW-1)));
        rd_check(4'd4, "R2 flip both ends");

        // R5: read correction leaves storage unrepaired
        wr(4'd5, 32'h1234_5678, CW'(1) << 17);
        rd_check(4'd5, "R5 first read");
        rd_check(4'd5, "R5 second read");

        // Random mix with scrubbing off; R8 monitors for scrub pulses
        mon_on = 1; scrub_events = 0;
        for (int k = 0; k < 80; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(DEPTH-1));
            if ($urandom_range(1) == 0) begin
                case ($urandom_range(2))
                    0: wr(a, $urandom, '0);
                    1: wr(a, $urandom, one_flip());
                    default: wr(a, $urandom, two_flip());
                endcase
            end else begin
                rd_check(a, "random");
            end
        end
        repeat (100) @(negedge clk);
        mon_on = 0;
        check(scrub_events == 0, "R8 no scrub with gap 0", 64'(scrub_events), 64'd0);

        // R10: back-to-back host reads, scrub enabled, every word correctable
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), $urandom, one_flip());
        @(negedge clk);
        scrub_gap = 8'd1;
        for (int n = 0; n < 26; n++) begin
            if (n >= 2) begin
                check(rsp_valid && rsp_rdata == mdata[(n-2) % DEPTH] && host_ce,
                      "R10 burst response", 64'(rsp_rdata), 64'(mdata[(n-2) % DEPTH]));
                check(!scrub_ce && !scrub_ue, "R10 no scrub during burst",
                      64'({scrub_ce, scrub_ue}), 64'd0);
            end
            if (n < 24) begin
                req_valid = 1; req_write = 0; req_addr = AW'(n % DEPTH);
            end else begin
                req_valid = 0;
            end
            if (n == 24) scrub_gap = 8'd5;
            @(negedge clk);
        end

        // R9: step period is gap+2 while every step corrects
        wait_ce(n1);
        wait_ce(n1);
        check(n1 == 5 + 2, "R9 period gap 5", 64'(n1), 64'd7);
        scrub_gap = 8'd1;
        wait_ce(n2);
        wait_ce(n2);
        check(n2 == 1 + 2, "R9 period gap 1", 64'(n2), 64'd3);
        scrub_gap = 8'd0;
        repeat (4) @(negedge clk);

        // R6 / R7: sweep with wrap, repair singles, leave doubles alone
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), $urandom, '0);
        wr(4'd0, 32'hCAFE_0000, one_flip());
        wr(4'd15, 32'h0000_BEEF, one_flip());
        wr(4'd7, 32'h7777_7777, two_flip());
        for (int i = 0; i < DEPTH; i++) begin seen_ce[i] = 0; seen_ue[i] = 0; end
        scrub_events = 0;
        mon_on = 1;
        @(negedge clk);
        scrub_gap = 8'd3;
        repeat (400) @(negedge clk);
        scrub_gap = 8'd0;
        repeat (4) @(negedge clk);
        mon_on = 0;
        check(seen_ce[0] == 1, "R6 scrub_ce at addr 0 (after wrap)", 64'(seen_ce[0]), 64'd1);
        check(seen_ce[15] == 1, "R6 scrub_ce at last addr", 64'(seen_ce[15]), 64'd1);
        check(seen_ue[7] >= 1, "R7 scrub_ue at addr 7", 64'(seen_ue[7]), 64'd1);
        check(seen_ce[7] == 0 && seen_ce[3] == 0, "R6 no scrub_ce on clean/double",
              64'(seen_ce[7] + seen_ce[3]), 64'd0);
        merr[0] = 0; merr[15] = 0;
        rd_check(4'd0, "R6 repaired addr 0");
        rd_check(4'd15, "R6 repaired last addr");
        rd_check(4'd7, "R7 double still flagged");

        // R11: host write cancels a pending scrub write-back
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), $urandom, '0);
        wr(4'd9, 32'h0BAD_0BAD, CW'(1) << 11);
        d2 = 32'h600D_600D;
        @(negedge clk);
        scrub_gap = 8'd1;
        hit = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (scrub_ce && err_addr == 4'd9) begin
                req_valid = 1; req_write = 1; req_addr = 4'd9; req_wdata = d2; req_flip = '0;
                @(negedge clk);
                req_valid = 0; req_write = 0;
                scrub_gap = 8'd0;
                hit = 1;
                break;
            end
        end
        check(hit, "R11 pending write-back reached", 64'(hit), 64'd1);
        mdata[9] = d2; merr[9] = 0;
        repeat (4) @(negedge clk);
        rd_check(4'd9, "R11 host data survives");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule